// File: doc/BRIEF.md
# Receive Byte Queue with Coded Fill Thresholds

This block holds the bytes that a serial receiver has assembled until the host picks them up. The receiver pushes one byte per write strobe. The host pops the oldest byte with a read strobe, and the byte shows up on a registered read-data output.

Two independent fill-level comparators watch the stored count. Each takes a 3-bit code that selects one of a fixed set of non-linear levels. The first comparator drives a data-available flag that tells the host enough bytes are waiting. The second drives a request-to-send pin that tells the far end to pause once the queue reaches its level. The pin's active polarity is selectable.

The depth defaults to 64 entries. A 16-entry build is selected by parameter, and the depth must be a power of two.

Top module: `rx_fill_queue`

## Requirements
- R1: After a synchronous active-low reset the queue is empty. The outputs are: `empty`=1, `full`=0, `overflow`=0, `rd_data`=0 and `data_avail`=0. The RTS logic reports ready.
- R2: Bytes are read out in the order they were written. A read strobe sampled at a clock edge puts the oldest stored byte on `rd_data` right after that edge.
- R3: `empty` is 1 exactly when no bytes are stored. `full` is 1 exactly when DEPTH bytes are stored. The stored count never exceeds DEPTH.
- R4: A write while `full` is 1 is dropped, even if a read happens in the same cycle, and it sets the sticky `overflow` flag. `ovf_clr` clears `overflow`. When a dropped write and `ovf_clr` fall in the same cycle, `overflow` ends up 1.
- R5: A read while `empty` is 1 leaves `rd_data` and the queue state unchanged. A byte written later is the next byte read.
- R6: Threshold codes map as follows: 0 to 1 byte, 1 to 4, 2 to 8, 3 to 14, 4 to 30, 5 to 46, 6 to 62, and 7 to 62. A level above DEPTH is clamped to DEPTH.
- R7: `data_avail` is 1 exactly when the stored count is at least the level selected by `rx_trig_code`. It follows the count in the same cycle the count changes.
- R8: RTS is ready when the stored count is below the level selected by `rts_trig_code`, and not ready otherwise. With `rts_low_active`=0 the pin equals ready. With `rts_low_active`=1 the pin is its inverse.
- R9: A read and a write in the same cycle, with the queue neither empty nor full, both take effect and leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Push strobe from the receiver |
| wr_data | input | 8 | Byte to push |
| rd_en | input | 1 | Pop strobe from the host |
| rd_data | output | 8 | Last byte popped (registered) |
| rx_trig_code | input | 3 | Data-available threshold code |
| rts_trig_code | input | 3 | RTS threshold code |
| rts_low_active | input | 1 | 1: RTS pin active low, 0: active high |
| ovf_clr | input | 1 | Clears the overflow flag |
| empty | output | 1 | No bytes stored |
| full | output | 1 | DEPTH bytes stored |
| overflow | output | 1 | Sticky: a write was dropped |
| data_avail | output | 1 | Count has reached the receive threshold |
| rts_pin | output | 1 | Flow-control pin |

## Verification
The embedded properties check on every cycle that the count stays bounded and moves by at most one step. They also check that a dropped write freezes the count and raises overflow, that an empty read leaves the read data untouched, that a balanced read-write keeps the count steady, and that the flags agree with each other at the extremes: when full, data-available is set and the RTS pin shows not-ready; when empty, data-available is clear. The full code-to-level mapping at the points just below and at each level, with both pin polarities, can only be shown by the bench's vector table. Byte ordering, the clamp behaviour and the overflow-clear collision are covered by directed scenarios.

// File: rtl/rxq_pkg.sv
// Shared helpers for the receive byte queue.
// Assumes threshold codes are 3 bits wide.
package rxq_pkg;

    localparam int CODE_W = 3;

    // Map a threshold code to a byte level (codes 6 and 7 both give 62).
    function automatic int unsigned code_to_level(input logic [CODE_W-1:0] code);
        int unsigned lvl;
        case (code)
            3'd0:    lvl = 1;
            3'd1:    lvl = 4;
            3'd2:    lvl = 8;
            3'd3:    lvl = 14;
            3'd4:    lvl = 30;
            3'd5:    lvl = 46;
            default: lvl = 62;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/rxq_store.sv
// Circular byte store with a fill counter, registered read data and a
// sticky overflow flag.
// Assumes DEPTH is a power of two, so the pointers wrap naturally.
module rxq_store #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              ovf_clr,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  count,
    output logic              empty,
    output logic              full,
    output logic              overflow
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic              do_wr;
    logic              do_rd;

    // Flags come straight from the counter.
    always_comb begin
        empty = (count == '0);
        full  = (count == CNT_W'(DEPTH));
        do_wr = wr_en && !full;
        do_rd = rd_en && !empty;
    end

    // Storage write; the array itself needs no reset.
    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    // Pointer and count bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= rd_ptr + 1'b1;
            if (do_wr && !do_rd)      count <= count + 1'b1;
            else if (do_rd && !do_wr) count <= count - 1'b1;
        end
    end

    // Registered read data; holds its value on an empty read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (do_rd) begin
            rd_data <= mem[rd_ptr];
        end
    end

    // Sticky overflow; a new drop wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overflow <= 1'b0;
        end else if (wr_en && full) begin
            overflow <= 1'b1;
        end else if (ovf_clr) begin
            overflow <= 1'b0;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R3
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (count == $past(count)) || (count == $past(count) + 1'b1)
        || (count == $past(count) - 1'b1)); // R3
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        full && wr_en && !rd_en |=> $stable(count)); // R4
    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        full && wr_en |=> overflow); // R4
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        empty && rd_en && !wr_en |=> $stable(rd_data) && empty); // R5
    AST_RW_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
        !empty && !full && wr_en && rd_en |=> $stable(count)); // R9

endmodule

// File: rtl/rxq_level_cmp.sv
// Decodes a threshold code into a byte level, clamps it to the depth and
// compares it with the current fill count.
// Assumes the count never exceeds DEPTH.
module rxq_level_cmp
    import rxq_pkg::*;
#(
    parameter int DEPTH  = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CODE_W-1:0] code,
    input  logic [CNT_W-1:0]  count,
    output logic              reached
);

    int unsigned       raw_lvl;
    logic [CNT_W-1:0]  lvl;

    // Clamp the decoded level before narrowing it to the counter width.
    always_comb begin
        raw_lvl = code_to_level(code);
        if (raw_lvl > DEPTH) raw_lvl = DEPTH;
        lvl     = CNT_W'(raw_lvl);
        reached = (count >= lvl);
    end

endmodule

// File: rtl/rxq_rts_drive.sv
// Turns the RTS threshold compare into the pin level.
// Ready is the inverse of the level being reached; polarity 1 drives the
// pin low for ready.
module rxq_rts_drive (
    input  logic reached,
    input  logic low_active,
    output logic pin
);

    logic ready;

    // Map the ready state to the selected pin polarity.
    always_comb begin
        ready = !reached;
        pin   = low_active ? !ready : ready;
    end

endmodule

// File: rtl/rx_fill_queue.sv
// Receive byte queue top: the store plus two threshold comparators
// (index 0 for data-available, index 1 for RTS) and the RTS pin driver.
// Assumes DEPTH is a power of two and at least 2.
module rx_fill_queue
    import rxq_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic [2:0]        rx_trig_code,
    input  logic [2:0]        rts_trig_code,
    input  logic              rts_low_active,
    input  logic              ovf_clr,
    output logic              empty,
    output logic              full,
    output logic              overflow,
    output logic              data_avail,
    output logic              rts_pin
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int N_CMP = 2;

    logic [CNT_W-1:0]  count;
    logic [CODE_W-1:0] codes   [N_CMP];
    logic [N_CMP-1:0]  reached;

    // Gather both threshold codes for the comparator array.
    always_comb begin
        codes[0] = rx_trig_code;
        codes[1] = rts_trig_code;
    end

    rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .ovf_clr  (ovf_clr),
        .rd_data  (rd_data),
        .count    (count),
        .empty    (empty),
        .full     (full),
        .overflow (overflow)
    );

    for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
        rxq_level_cmp #(.DEPTH(DEPTH)) u_cmp (
            .code    (codes[g]),
            .count   (count),
            .reached (reached[g])
        );
    end

    rxq_rts_drive u_rts (
        .reached    (reached[1]),
        .low_active (rts_low_active),
        .pin        (rts_pin)
    );

    assign data_avail = reached[0];

    AST_DAV_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> data_avail); // R7
    AST_DAV_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !data_avail); // R7
    AST_RTS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (rts_pin == rts_low_active)); // R8
    AST_RTS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (rts_pin != rts_low_active)); // R8

endmodule

// File: tb/rx_fill_queue_test.sv
module rx_fill_queue_test;

    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [2:0] rx_trig_code = '0;
    logic [2:0] rts_trig_code = '0;
    logic       rts_low_active = 1'b0;
    logic       ovf_clr = 1'b0;
    logic       empty, full, overflow, data_avail, rts_pin;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    rx_fill_queue #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rx_trig_code(rx_trig_code),
        .rts_trig_code(rts_trig_code), .rts_low_active(rts_low_active),
        .ovf_clr(ovf_clr), .empty(empty), .full(full), .overflow(overflow),
        .data_avail(data_avail), .rts_pin(rts_pin)
    );

    // Vector: fill[15:9] rx_code[8:6] rts_code[5:3] pol[2] exp_avail[1] exp_pin[0]
    // Levels per R6; avail per R7; pin per R8.
    localparam logic [15:0] VEC [16] = '{
        {7'd0,  3'd0, 3'd0, 1'b0, 1'b0, 1'b1},
        {7'd1,  3'd0, 3'd0, 1'b0, 1'b1, 1'b0},
        {7'd3,  3'd1, 3'd1, 1'b1, 1'b0, 1'b0},
        {7'd4,  3'd1, 3'd1, 1'b1, 1'b1, 1'b1},
        {7'd7,  3'd2, 3'd3, 1'b0, 1'b0, 1'b1},
        {7'd8,  3'd2, 3'd2, 1'b0, 1'b1, 1'b0},
        {7'd13, 3'd3, 3'd4, 1'b1, 1'b0, 1'b0},
        {7'd14, 3'd3, 3'd3, 1'b1, 1'b1, 1'b1},
        {7'd29, 3'd4, 3'd5, 1'b0, 1'b0, 1'b1},
        {7'd30, 3'd4, 3'd4, 1'b0, 1'b1, 1'b0},
        {7'd45, 3'd5, 3'd6, 1'b1, 1'b0, 1'b0},
        {7'd46, 3'd5, 3'd5, 1'b1, 1'b1, 1'b1},
        {7'd61, 3'd6, 3'd7, 1'b0, 1'b0, 1'b1},
        {7'd62, 3'd6, 3'd6, 1'b0, 1'b1, 1'b0},
        {7'd62, 3'd7, 3'd7, 1'b1, 1'b1, 1'b1},
        {7'd61, 3'd7, 3'd0, 1'b1, 1'b0, 1'b1}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; ovf_clr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic push(input logic [7:0] b);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pop();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int mism;
        // Table walk: R6, R7, R8
        for (int v = 0; v < 16; v++) begin
            do_reset();
            for (int k = 0; k < int'(VEC[v][15:9]); k++) push(8'(k));
            rx_trig_code = VEC[v][8:6];
            rts_trig_code = VEC[v][5:3];
            rts_low_active = VEC[v][2];
            #1;
            chk($sformatf("R7 vec%0d data_avail", v), int'(data_avail), int'(VEC[v][1]));
            chk($sformatf("R8 vec%0d rts_pin", v), int'(rts_pin), int'(VEC[v][0]));
        end

        // R1 reset state
        rx_trig_code = 3'd0; rts_trig_code = 3'd0; rts_low_active = 1'b0;
        do_reset();
        #1;
        chk("R1 empty", int'(empty), 1);
        chk("R1 full", int'(full), 0);
        chk("R1 overflow", int'(overflow), 0);
        chk("R1 rd_data", int'(rd_data), 0);
        chk("R1 data_avail", int'(data_avail), 0);
        chk("R1 rts ready", int'(rts_pin), 1);

        // R2 ordering
        for (int i = 0; i < 5; i++) push(8'hA0 + 8'(i));
        for (int i = 0; i < 5; i++) begin
            pop();
            chk("R2 order", int'(rd_data), 'hA0 + i);
        end
        chk("R3 empty after drain", int'(empty), 1);

        // R3, R4 fill to full, drop a write
        for (int i = 0; i < DEPTH; i++) push(8'(i) ^ 8'h3C);
        chk("R3 full", int'(full), 1);
        chk("R3 not empty", int'(empty), 0);
        push(8'hEE);
        chk("R4 overflow set", int'(overflow), 1);
        chk("R4 still full", int'(full), 1);
        mism = 0;
        for (int i = 0; i < DEPTH; i++) begin
            pop();
            if (rd_data != (8'(i) ^ 8'h3C)) mism++;
        end
        chk("R4 contents intact", mism, 0);
        chk("R4 dropped byte absent", int'(empty), 1);

        // R5 empty read
        pop();
        chk("R5 rd_data held", int'(rd_data), int'(8'(DEPTH - 1) ^ 8'h3C));
        chk("R5 still empty", int'(empty), 1);
        push(8'h77);
        pop();
        chk("R5 next byte", int'(rd_data), 'h77);

        // R4 sticky, clear, clear collision
        chk("R4 sticky", int'(overflow), 1);
        ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
        chk("R4 cleared", int'(overflow), 0);
        for (int i = 0; i < DEPTH; i++) push(8'(i));
        ovf_clr = 1'b1; wr_en = 1'b1; rd_en = 1'b1; wr_data = 8'h99;
        @(negedge clk);
        ovf_clr = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        chk("R4 set wins over clear", int'(overflow), 1);
        chk("R4 write with read at full dropped", int'(full), 0);

        // R9 simultaneous read and write
        do_reset();
        push(8'h11); push(8'h22);
        rx_trig_code = 3'd0;
        wr_en = 1'b1; wr_data = 8'h33; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R9 read side", int'(rd_data), 'h11);
        pop();
        chk("R9 second", int'(rd_data), 'h22);
        pop();
        chk("R9 written byte", int'(rd_data), 'h33);
        chk("R9 empty after", int'(empty), 1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule